// File: doc/BRIEF.md
# Cascaded Wide Fan-In Decoder

This block evaluates one Boolean function of `4*NCELL` input bits. It does this with a row of `NCELL` small look-up cells. Each cell takes its own four input bits and a 16-entry truth table, and produces one partial result. All cells work side by side. A serial cascade path then merges their partial results, running from cell 0 up to the last cell. The merge is a logical AND. OR is also available: each partial result is inverted before it enters the AND path, and the end of the path is inverted again.

Cells are grouped into clusters of `CLUSTER` cells. The cascade leaves the last cell of one cluster and enters the first cell of the next, so one chain can be any length. A typical use is an address comparator. Cell k holds a one-hot table that matches nibble `data[4k+3:4k]`, and the AND chain reports a full match.

Input beats carry the data vector, the truth tables and the combine mode, and use a valid/ready handshake. Each accepted beat yields one registered output beat, which holds the final result and the cascade value at every cell. The output beat is valid/ready too. A stalled output blocks new input, so back-pressure passes straight through and no beat is dropped or duplicated.

Top module: `wfd_decoder`

## Requirements
- R1: After reset, out_valid is 0 and stays 0 until a beat is accepted.
- R2: Cell k reads truth-table bits lut_cfg[16k+15:16k]. Its index is the nibble in_data[4k+3:4k], and table bit i is the cell output for nibble value i.
- R3: With or_mode = 0, out_result is the AND of all cell outputs.
- R4: With or_mode = 1, out_result is the OR of all cell outputs. It is built by inverting each cell output, chaining with AND, and inverting the end of the chain.
- R5: out_taps[k] is the cascade value after cell k. It is the AND of the cell terms for cells 0..k, where a cell's term is its output, inverted when or_mode = 1. The chain starts from the constant 1.
- R6: The cascade crosses cluster boundaries. The first cell of each cluster takes its cascade input from the last cell of the previous cluster.
- R7: in_ready is 1 exactly when out_valid is 0 or out_ready is 1. A beat is accepted on a clock edge where in_valid and in_ready are both 1, and its result appears with out_valid = 1 after that edge.
- R8: While out_valid = 1 and out_ready = 0, out_valid, out_result and out_taps hold their values.
- R9: The taps are monotone. If out_taps[k] is 0, then every higher tap is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 4*NCELL | Function inputs; nibble k feeds cell k |
| lut_cfg | input | 16*NCELL | Truth tables; 16 bits per cell |
| or_mode | input | 1 | 0 = AND combine, 1 = OR combine |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_result | output | 1 | Final decode result |
| out_taps | output | NCELL | Cascade value after each cell |

## Verification
Random truth tables and random data are run in both combine modes. These beats are compared with a flat reference, which shows whether each cell indexes its own table slice. Directed one-hot equality tables are then applied: first a full match, then a mismatch in a single nibble placed just past a cluster boundary. The tap vector then shows whether the chain links correctly across clusters and in the right direction. Tables that are all zero or all one separate AND behaviour from OR behaviour. A stalled output, with new input waiting, shows that back-pressure holds the output and neither drops nor replaces the beat. Two chain lengths are used: one longer than a cluster, and one with several short clusters.

// File: rtl/wfd_pkg.sv
package wfd_pkg;
  localparam int NIB_W  = 4;
  localparam int TT_W   = 16;

  function automatic int clust_count(input int ncell, input int csize);
    return (ncell + csize - 1) / csize;
  endfunction

  function automatic int clust_cells(input int ncell, input int csize, input int idx);
    int rem;
    rem = ncell - idx * csize;
    return (rem < csize) ? rem : csize;
  endfunction
endpackage

// File: rtl/wfd_cell.sv
module wfd_cell
  import wfd_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  input  logic [TT_W-1:0]  tt,
  input  logic             or_mode,
  input  logic             casc_in,
  output logic             casc_out
);
  logic lut_q;
  logic term;

  always_comb begin
    lut_q    = tt[nib];
    term     = or_mode ? ~lut_q : lut_q;
    casc_out = casc_in & term;
  end
endmodule

// File: rtl/wfd_cluster.sv
module wfd_cluster
  import wfd_pkg::*;
#(
  parameter int CELLS = 8
) (
  input  logic                   casc_in,
  input  logic [NIB_W*CELLS-1:0] data,
  input  logic [TT_W*CELLS-1:0]  cfg,
  input  logic                   or_mode,
  output logic [CELLS-1:0]       taps,
  output logic                   casc_out
);
  logic [CELLS:0] link;

  assign link[0] = casc_in;

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    wfd_cell u_cell (
      .nib      (data[k*NIB_W +: NIB_W]),
      .tt       (cfg[k*TT_W +: TT_W]),
      .or_mode  (or_mode),
      .casc_in  (link[k]),
      .casc_out (link[k+1])
    );
    assign taps[k] = link[k+1];
  end

  assign casc_out = link[CELLS];
endmodule

// File: rtl/wfd_decoder.sv
module wfd_decoder
  import wfd_pkg::*;
#(
  parameter int NCELL   = 12,
  parameter int CLUSTER = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NIB_W*NCELL-1:0] in_data,
  input  logic [TT_W*NCELL-1:0]  lut_cfg,
  input  logic                   or_mode,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic                   out_result,
  output logic [NCELL-1:0]       out_taps
);
  localparam int NCLUST = clust_count(NCELL, CLUSTER);

  logic [NCLUST:0]  chain;
  logic [NCELL-1:0] taps_d;
  logic             result_d;
  logic             accept;

  // chain starts from the AND identity
  assign chain[0] = 1'b1;

  for (genvar c = 0; c < NCLUST; c++) begin : g_clust
    localparam int BASE = c * CLUSTER;
    localparam int CNT  = clust_cells(NCELL, CLUSTER, c);
    wfd_cluster #(.CELLS(CNT)) u_clust (
      .casc_in  (chain[c]),
      .data     (in_data[BASE*NIB_W +: CNT*NIB_W]),
      .cfg      (lut_cfg[BASE*TT_W +: CNT*TT_W]),
      .or_mode  (or_mode),
      .taps     (taps_d[BASE +: CNT]),
      .casc_out (chain[c+1])
    );
  end

  assign result_d = or_mode ? ~chain[NCLUST] : chain[NCLUST];
  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= 1'b0;
      out_taps   <= '0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        out_result <= result_d;
        out_taps   <= taps_d;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wfd_decoder_chk.sv
module wfd_decoder_chk #(
  parameter int NCELL = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_result,
  input logic [NCELL-1:0] out_taps
);
  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  // R7
  accept_gives_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R7
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_taps)));

  // R9
  taps_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((out_taps >> 1) & ~out_taps) == '0));
endmodule

bind wfd_decoder wfd_decoder_chk #(.NCELL(NCELL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_taps   (out_taps)
);

// File: tb/sim_wfd_decoder.sv
module sim_wfd_decoder;
  localparam int N0 = 12;
  localparam int N1 = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic or_mode = 1'b0;
  logic [4*N0-1:0]  in_data = '0;
  logic [16*N0-1:0] lut_cfg = '0;
  logic rdy0, rdy1, ov0, ov1, res0, res1;
  logic [N0-1:0] taps0;
  logic [N1-1:0] taps1;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wfd_decoder #(.NCELL(N0), .CLUSTER(8)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy0),
    .in_data(in_data), .lut_cfg(lut_cfg), .or_mode(or_mode),
    .out_valid(ov0), .out_ready(out_ready), .out_result(res0), .out_taps(taps0));

  wfd_decoder #(.NCELL(N1), .CLUSTER(2)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1),
    .in_data(in_data[4*N1-1:0]), .lut_cfg(lut_cfg[16*N1-1:0]), .or_mode(or_mode),
    .out_valid(ov1), .out_ready(out_ready), .out_result(res1), .out_taps(taps1));

  function automatic logic [N0-1:0] ref_taps(input logic [16*N0-1:0] tt,
      input logic [4*N0-1:0] d, input int n, input bit orm);
    logic [N0-1:0] t;
    logic acc;
    t = '0;
    acc = 1'b1;
    for (int k = 0; k < n; k++) begin
      logic bitv;
      bitv = tt[16*k + d[4*k +: 4]];
      acc = acc & (orm ? ~bitv : bitv);
      t[k] = acc;
    end
    return t;
  endfunction

  function automatic logic ref_result(input logic [16*N0-1:0] tt,
      input logic [4*N0-1:0] d, input int n, input bit orm);
    logic r;
    r = orm ? 1'b0 : 1'b1;
    for (int k = 0; k < n; k++) begin
      if (orm) r = r | tt[16*k + d[4*k +: 4]];
      else     r = r & tt[16*k + d[4*k +: 4]];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_both(input string req);
    logic [N0-1:0] e0;
    logic [N0-1:0] e1;
    e0 = ref_taps(lut_cfg, in_data, N0, or_mode);
    e1 = ref_taps(lut_cfg, in_data, N1, or_mode);
    chk(ov0 && taps0 == e0, {req, " taps n=12"}, {52'h0, taps0}, {52'h0, e0});
    chk(ov0 && res0 == ref_result(lut_cfg, in_data, N0, or_mode), {req, " result n=12"},
        {63'h0, res0}, {63'h0, ref_result(lut_cfg, in_data, N0, or_mode)});
    chk(ov1 && taps1 == e1[N1-1:0], {req, " taps n=5"}, {59'h0, taps1}, {59'h0, e1[N1-1:0]});
    chk(ov1 && res1 == ref_result(lut_cfg, in_data, N1, or_mode), {req, " result n=5"},
        {63'h0, res1}, {63'h0, ref_result(lut_cfg, in_data, N1, or_mode)});
  endtask

  // drive one beat at negedge, accepted at posedge, checked at next negedge
  task automatic beat(input logic [4*N0-1:0] d, input logic [16*N0-1:0] tt, input bit m,
      input string req);
    @(negedge clk);
    in_data = d; lut_cfg = tt; or_mode = m; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_both(req);
  endtask

  function automatic logic [16*N0-1:0] match_tables(input logic [4*N0-1:0] pat);
    logic [16*N0-1:0] t;
    t = '0;
    for (int k = 0; k < N0; k++) t[16*k + pat[4*k +: 4]] = 1'b1;
    return t;
  endfunction

  initial begin
    logic [4*N0-1:0] pat;
    logic [16*N0-1:0] tt;
    logic sres;
    logic [N0-1:0] staps;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: idle after reset
    chk(!ov0 && !ov1, "R1 out_valid in reset", {62'h0, ov0, ov1}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!ov0 && !ov1, "R1 out_valid after reset", {62'h0, ov0, ov1}, 64'h0);
    chk(rdy0 && rdy1, "R7 ready when idle", {62'h0, rdy0, rdy1}, 64'h3);

    // R3 R6: address match across cluster boundary
    pat = {$urandom, $urandom};
    tt = match_tables(pat);
    beat(pat, tt, 1'b0, "R3 R6 full match");
    chk(res0 == 1'b1 && taps0 == '1, "R3 match all taps", {52'h0, taps0}, 64'hfff);
    beat(pat ^ (48'h1 << 36), tt, 1'b0, "R6 mismatch cell 9");
    chk(taps0 == 12'h1ff && res0 == 1'b0, "R6 chain crosses cluster", {52'h0, taps0}, 64'h1ff);
    beat(pat ^ 48'h8, tt, 1'b0, "R5 mismatch cell 0");
    chk(taps0 == '0, "R5 first cell kills chain", {52'h0, taps0}, 64'h0);

    // R4: OR mode with empty and one-cell tables
    beat(pat, '0, 1'b1, "R4 all-zero tables");
    chk(res0 == 1'b0 && taps0 == '1, "R4 or of zeros", {51'h0, res0, taps0}, 64'hfff);
    beat(pat, {16'h0, 16'hffff, 160'h0}, 1'b1, "R4 cell 10 true");
    chk(res0 == 1'b1 && taps0 == 12'h3ff, "R4 or one cell", {51'h0, res0, taps0}, 64'h13ff);
    beat(pat, '1, 1'b0, "R3 all-one tables");

    // R2 R3 R4 R5: random tables and data in both modes
    for (int i = 0; i < 200; i++) begin
      logic [4*N0-1:0] d;
      logic [16*N0-1:0] t;
      d = {$urandom, $urandom};
      for (int w = 0; w < 6; w++) t[32*w +: 32] = $urandom;
      // bias toward true entries so AND chains reach far
      if (i % 2 == 0) for (int w = 0; w < 6; w++) t[32*w +: 32] = t[32*w +: 32] | $urandom;
      beat(d, t, i[2], "R2 R5 random");
    end

    // R8 R7: stall with a new beat waiting
    @(negedge clk);
    pat = {$urandom, $urandom};
    in_data = pat; lut_cfg = match_tables(pat); or_mode = 1'b0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    sres = res0; staps = taps0;
    chk(ov0 && sres == 1'b1, "R7 beat captured", {63'h0, sres}, 64'h1);
    in_data = pat ^ 48'h1;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk(!rdy0 && !rdy1, "R7 ready low while stalled", {62'h0, rdy0, rdy1}, 64'h0);
      chk(ov0 && res0 == sres && taps0 == staps, "R8 hold on stall",
          {51'h0, res0, taps0}, {51'h0, sres, staps});
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(ov0 && res0 == 1'b0, "R7 waiting beat taken after release", {63'h0, res0}, 64'h0);
    @(negedge clk);
    chk(!ov0 && !ov1, "R7 idle after drain", {62'h0, ov0, ov1}, 64'h0);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule